// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Encoder

This block turns a 24-bit word into one serial infrared frame and emits it one level per sample tick. A frame opens with a long header pulse at the active level and a shorter inactive pause. After that come the data bits. Each bit is an inactive space of variable length followed by an active pulse of fixed length. The length of the space carries the bit value: a one has twice the space of a zero.

A single-cycle start pulse captures the word and raises busy. The output then advances by one sample each time the sample-enable input is high, and does nothing in other cycles. Once every bit has been sent the line stays inactive. The frame is always cut off after a fixed number of samples, and busy then drops. A parameter selects an inverted output polarity for drivers whose active level is low.

Top module: `irf_encoder`

## Requirements
- R1: After a synchronous active-low reset, busy is low and the output is at the inactive level (0, or 1 when the polarity is inverted). This holds whenever busy is low.
- R2: A start pulse while idle captures the payload and raises busy in the following cycle, with the output at the active level. A sample tick in the accepting cycle is not consumed. Later changes of the payload input have no effect on the frame.
- R3: The header is 32 samples at the active level, followed by 8 samples at the inactive level.
- R4: The 24 payload bits follow the header, least significant bit (bit 0) first.
- R5: A one bit is 16 inactive samples followed by 8 active samples.
- R6: A zero bit is 8 inactive samples followed by 8 active samples.
- R7: After the mark of the last bit, the output stays inactive until the frame ends.
- R8: Every frame lasts exactly 601 samples, at positions 0 to 600. The tick at position 600 clears busy, which truncates any frame that would run longer.
- R9: A start pulse while busy is ignored, along with the payload presented with it.
- R10: The output and the frame position change only in cycles where the sample tick is high.
- R11: With the polarity parameter set, every output sample is the complement of the non-inverted output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a frame when idle |
| payload_i | input | 24 | Word to transmit, captured on an accepted start |
| tick_i | input | 1 | Sample enable: advances the frame by one sample |
| level_o | output | 1 | Serial line level |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench builds two copies of the block with default timing: one with normal polarity and one with inverted polarity. Both are compared on every clock against a single model. The default 600-sample stop limit is below the 616 samples that an all-ones word needs, so the truncation path is reached with real data. The all-zeros word exercises the long inactive tail. Running the tick at every cycle and at every third cycle exposes any advance that does not wait for the tick.

// File: rtl/irf_pkg.sv
// Shared types for the infrared frame encoder.
// Assumes: nothing beyond the segment ordering used by the sequencer.
package irf_pkg;

    // Segment of the frame that is currently being emitted.
    typedef enum logic [2:0] {
        SEG_IDLE  = 3'd0,
        SEG_HMARK = 3'd1,
        SEG_HGAP  = 3'd2,
        SEG_SPACE = 3'd3,
        SEG_MARK  = 3'd4,
        SEG_TAIL  = 3'd5
    } seg_t;

    // Larger of two non-negative lengths, used to size counters.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // True when the segment drives the active line level.
    function automatic logic seg_is_active(input seg_t s);
        return (s == SEG_HMARK) || (s == SEG_MARK);
    endfunction

endpackage

// File: rtl/irf_payload_shift.sv
// Holds the word being transmitted and shifts it right once per finished bit.
// Assumes: load and shift are never both high; NBITS is at least 2.
module irf_payload_shift #(
    parameter int unsigned NBITS = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [NBITS-1:0] word_i,
    input  logic             shift_i,
    output logic             bit_now_o,
    output logic             bit_next_o
);

    logic [NBITS-1:0] word_q;

    // Capture on load, discard the sent bit on shift.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
        end else if (shift_i) begin
            word_q <= word_q >> 1;
        end
    end

    assign bit_now_o  = word_q[0];
    assign bit_next_o = word_q[1];

    // R2: loading and shifting are exclusive requests.
    p_load_shift_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && shift_i))
        else $error("load and shift together");

endmodule

// File: rtl/irf_position.sv
// Counts the sample position inside a frame and raises the stop request
// on the tick that arrives at the last allowed position.
// Assumes: clear and advance never coincide (clear only happens while idle).
module irf_position #(
    parameter int unsigned STOP_LIMIT = 600
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic adv_i,
    output logic stop_o
);

    localparam int unsigned PW = $clog2(STOP_LIMIT + 1);

    logic [PW-1:0] pos_q;

    // Position register: zeroed on a new frame, +1 per consumed sample.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            pos_q <= '0;
        end else if (adv_i && (pos_q != PW'(STOP_LIMIT))) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign stop_o = adv_i && (pos_q == PW'(STOP_LIMIT));

    // R8: the position never runs past the stop limit.
    p_pos_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q <= PW'(STOP_LIMIT))
        else $error("position beyond stop limit");

    // R10: without an advance the position holds.
    p_pos_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !clear_i) |=> $stable(pos_q))
        else $error("position moved without a tick");

endmodule

// File: rtl/irf_sequencer.sv
// Walks the frame segments: header mark, header gap, then space/mark pairs
// per bit, then an inactive tail. Each segment lasts a parameter number of ticks.
// Assumes: every length parameter is at least 1; stop_i only pulses with a tick.
module irf_sequencer
    import irf_pkg::*;
#(
    parameter int unsigned NBITS      = 24,
    parameter int unsigned HDR_MARK   = 32,
    parameter int unsigned HDR_GAP    = 8,
    parameter int unsigned BIT_MARK   = 8,
    parameter int unsigned SPACE_ONE  = 16,
    parameter int unsigned SPACE_ZERO = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic tick_i,
    input  logic stop_i,
    input  logic bit_now_i,
    input  logic bit_next_i,
    output logic load_o,
    output logic shift_o,
    output seg_t seg_o,
    output logic busy_o
);

    localparam int unsigned MAXLEN = max2(max2(HDR_MARK, HDR_GAP),
                                          max2(BIT_MARK, max2(SPACE_ONE, SPACE_ZERO)));
    localparam int unsigned CW     = $clog2(MAXLEN + 1);
    localparam int unsigned IW     = (NBITS > 1) ? $clog2(NBITS) : 1;

    seg_t          seg_q, seg_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [IW-1:0] idx_q, idx_n;

    // Ticks left in a space for a given bit value, minus one.
    function automatic logic [CW-1:0] space_len(input logic b);
        return b ? CW'(SPACE_ONE - 1) : CW'(SPACE_ZERO - 1);
    endfunction

    // Next-state logic: accept a start when idle, else step on each tick.
    always_comb begin
        seg_n   = seg_q;
        cnt_n   = cnt_q;
        idx_n   = idx_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        if (seg_q == SEG_IDLE) begin
            if (start_i) begin
                load_o = 1'b1;
                seg_n  = SEG_HMARK;
                cnt_n  = CW'(HDR_MARK - 1);
                idx_n  = '0;
            end
        end else if (tick_i) begin
            if (stop_i) begin
                seg_n = SEG_IDLE;
                cnt_n = '0;
            end else if (cnt_q != '0) begin
                cnt_n = cnt_q - 1'b1;
            end else begin
                unique case (seg_q)
                    SEG_HMARK: begin
                        seg_n = SEG_HGAP;
                        cnt_n = CW'(HDR_GAP - 1);
                    end
                    SEG_HGAP: begin
                        seg_n = SEG_SPACE;
                        cnt_n = space_len(bit_now_i);
                    end
                    SEG_SPACE: begin
                        seg_n = SEG_MARK;
                        cnt_n = CW'(BIT_MARK - 1);
                    end
                    SEG_MARK: begin
                        if (idx_q == IW'(NBITS - 1)) begin
                            seg_n = SEG_TAIL;
                        end else begin
                            seg_n   = SEG_SPACE;
                            idx_n   = idx_q + 1'b1;
                            shift_o = 1'b1;
                            cnt_n   = space_len(bit_next_i);
                        end
                    end
                    default: begin
                        seg_n = seg_q;
                    end
                endcase
            end
        end
    end

    // State registers for segment, remaining ticks and bit index.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seg_q <= SEG_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            seg_q <= seg_n;
            cnt_q <= cnt_n;
            idx_q <= idx_n;
        end
    end

    assign seg_o  = seg_q;
    assign busy_o = (seg_q != SEG_IDLE);

    // R2: an accepted start always opens with the header mark.
    p_start_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q == SEG_IDLE && start_i) |=> (seg_q == SEG_HMARK))
        else $error("start did not open the header");

    // R9: a start while busy without a tick leaves the sequencer untouched.
    p_busy_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q != SEG_IDLE && start_i && !tick_i) |=> ($stable(seg_q) && $stable(cnt_q) && $stable(idx_q)))
        else $error("start while busy changed state");

    // R8: the stop request always returns the sequencer to idle.
    p_stop_to_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q != SEG_IDLE && tick_i && stop_i) |=> (seg_q == SEG_IDLE))
        else $error("stop did not end the frame");

    // R7: once in the tail only the stop leaves it.
    p_tail_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_q == SEG_TAIL) |=> (seg_q == SEG_TAIL || seg_q == SEG_IDLE))
        else $error("tail left without stop");

    // R4: the bit index never exceeds the word length.
    p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_q <= IW'(NBITS - 1))
        else $error("bit index out of range");

endmodule

// File: rtl/irf_polarity.sv
// Maps the internal active flag onto the line level chosen by INVERT.
// Assumes: INVERT is 0 or 1.
module irf_polarity #(
    parameter bit INVERT = 1'b0
) (
    input  logic active_i,
    output logic level_o
);

    // Polarity variant picked at elaboration.
    generate
        if (INVERT) begin : g_inv
            assign level_o = ~active_i;
        end else begin : g_direct
            assign level_o = active_i;
        end
    endgenerate

endmodule

// File: rtl/irf_encoder.sv
// Top of the infrared pulse-distance frame encoder: sequencer, payload
// shifter, position/stop counter and polarity stage.
// Assumes: tick_i is a single-cycle enable at the sample rate.
module irf_encoder
    import irf_pkg::*;
#(
    parameter int unsigned NBITS      = 24,
    parameter int unsigned HDR_MARK   = 32,
    parameter int unsigned HDR_GAP    = 8,
    parameter int unsigned BIT_MARK   = 8,
    parameter int unsigned SPACE_ONE  = 16,
    parameter int unsigned SPACE_ZERO = 8,
    parameter int unsigned STOP_LIMIT = 600,
    parameter bit          INVERT     = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NBITS-1:0] payload_i,
    input  logic             tick_i,
    output logic             level_o,
    output logic             busy_o
);

    logic load, shift, stop, bit_now, bit_next, busy, active;
    seg_t seg;

    irf_sequencer #(
        .NBITS(NBITS), .HDR_MARK(HDR_MARK), .HDR_GAP(HDR_GAP),
        .BIT_MARK(BIT_MARK), .SPACE_ONE(SPACE_ONE), .SPACE_ZERO(SPACE_ZERO)
    ) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
        .stop_i(stop), .bit_now_i(bit_now), .bit_next_i(bit_next),
        .load_o(load), .shift_o(shift), .seg_o(seg), .busy_o(busy)
    );

    irf_payload_shift #(.NBITS(NBITS)) u_word (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .word_i(payload_i),
        .shift_i(shift), .bit_now_o(bit_now), .bit_next_o(bit_next)
    );

    irf_position #(.STOP_LIMIT(STOP_LIMIT)) u_pos (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load),
        .adv_i(tick_i && busy), .stop_o(stop)
    );

    assign active = seg_is_active(seg);

    irf_polarity #(.INVERT(INVERT)) u_pol (
        .active_i(active), .level_o(level_o)
    );

    assign busy_o = busy;

    // R1: an idle encoder sits at the inactive level.
    p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (level_o == INVERT))
        else $error("idle level not inactive");

    // R10: no tick while busy means the line holds its level.
    p_hold_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i) |=> ($stable(level_o) && busy_o))
        else $error("level changed without a tick");

    // R3: an accepted start puts the line at the active level next cycle.
    p_start_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (level_o != INVERT))
        else $error("header did not start active");

endmodule

// File: tb/irf_encoder_tb_top.sv
// Bench: one behavioural model (sample queue) compared every clock against
// a normal-polarity and an inverted-polarity encoder.
module irf_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic [23:0] payload = '0;
    logic        lvl, bsy, lvl_inv, bsy_inv;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irf_encoder dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .payload_i(payload),
        .tick_i(tick), .level_o(lvl), .busy_o(bsy)
    );

    irf_encoder #(.INVERT(1'b1)) dut_inv_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .payload_i(payload),
        .tick_i(tick), .level_o(lvl_inv), .busy_o(bsy_inv)
    );

    // Reference model state.
    bit    q_lvl[$];
    string q_tag[$];
    bit    m_busy = 1'b0;
    bit    m_busy_prev = 1'b0;
    bit    last_tick = 1'b0;
    logic  prev_lvl = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void build_frame(input logic [23:0] w);
        q_lvl.delete();
        q_tag.delete();
        repeat (32) begin q_lvl.push_back(1'b1); q_tag.push_back("R3"); end
        repeat (8)  begin q_lvl.push_back(1'b0); q_tag.push_back("R3"); end
        for (int i = 0; i < 24; i++) begin
            string t;
            t = w[i] ? "R4,R5" : "R4,R6";
            repeat (w[i] ? 16 : 8) begin q_lvl.push_back(1'b0); q_tag.push_back(t); end
            repeat (8) begin q_lvl.push_back(1'b1); q_tag.push_back(t); end
        end
        while (q_lvl.size() < 601) begin q_lvl.push_back(1'b0); q_tag.push_back("R7"); end
        while (q_lvl.size() > 601) begin void'(q_lvl.pop_back()); void'(q_tag.pop_back()); end
    endfunction

    // Model step at each rising edge.
    always @(posedge clk) begin
        m_busy_prev = m_busy;
        last_tick   = tick;
        if (!rst_n) begin
            m_busy = 1'b0;
            q_lvl.delete();
            q_tag.delete();
        end else if (!m_busy) begin
            if (start) begin
                build_frame(payload);
                m_busy = 1'b1;
            end
        end else if (tick) begin
            void'(q_lvl.pop_front());
            void'(q_tag.pop_front());
            if (q_lvl.size() == 0) m_busy = 1'b0;
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        bit    exp_lvl;
        string tag;
        exp_lvl = m_busy ? q_lvl[0] : 1'b0;
        tag     = m_busy ? q_tag[0] : "R1";
        check(bsy === m_busy, "R2,R8 busy", int'(bsy), int'(m_busy));
        check(lvl === exp_lvl, tag, int'(lvl), int'(exp_lvl));
        check(lvl_inv === ~exp_lvl, "R11", int'(lvl_inv), int'(~exp_lvl));
        check(bsy_inv === m_busy, "R11 busy", int'(bsy_inv), int'(m_busy));
        if (m_busy && m_busy_prev && !last_tick)
            check(lvl === prev_lvl, "R10", int'(lvl), int'(prev_lvl));
        prev_lvl = lvl;
    end

    // Send one frame; tick every 'period' cycles, optional start injection.
    task automatic run_frame(input logic [23:0] w, input int period, input int inject_at);
        int n;
        @(negedge clk);
        payload = w; start = 1'b1; tick = 1'b1;   // R2: tick on accept cycle not consumed
        @(negedge clk);
        start = 1'b0; payload = ~w;               // R2: later payload changes ignored
        n = 0;
        while (m_busy) begin
            tick = ((n % period) == 0);
            if (n == inject_at) begin
                start = 1'b1; payload = 24'h5A5A5A;   // R9: ignored while busy
            end else begin
                start = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        start = 1'b0; tick = 1'b1;
        repeat (5) @(negedge clk);                // R7/R1 idle after frame
        tick = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, ticks alone do nothing.
        tick = 1'b1;
        repeat (3) @(negedge clk);
        check(lvl === 1'b0 && bsy === 1'b0, "R1", int'(lvl), 0);
        check(lvl_inv === 1'b1, "R1,R11", int'(lvl_inv), 1);
        tick = 1'b0;

        run_frame(24'hA5C33C, 1, -1);       // mixed bits, tick every cycle
        run_frame(24'h000000, 3, 100);      // zeros, sparse ticks, R9 injection
        run_frame(24'hFFFFFF, 1, 300);      // ones: truncated by the stop (R8)
        run_frame(24'h000001, 2, 5);        // single one first, R4 ordering

        // Reset in the middle of a frame returns to idle (R1).
        @(negedge clk);
        payload = 24'h123456; start = 1'b1; tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(bsy === 1'b0 && lvl === 1'b0, "R1 mid-frame reset", int'(bsy), 0);
        rst_n = 1'b1;
        run_frame(24'h800000, 1, -1);       // last bit only set

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule